// File: doc/BRIEF.md
# Interlaced Raster Sync Generator

This block produces the master timing for an interlaced 525-line or 625-line raster from a clock running at twice the luminance sample rate. The pixel counter advances once every two clock cycles. From it the block derives a line counter and a field number, an active-low horizontal sync, and an active-low vertical sync. The vertical sync pin can instead carry field parity. An active-video flag marks the 720-pixel picture region so that downstream blanking, burst and colour logic can key off the same counters.

The raster standard and the vertical pin function are captured from input pins while the sleep input is high. They stay fixed for as long as timing runs. Sleep also acts as a synchronous restart: the counters go back to the first pixel of line 1 of field 1, which is where vertical sync starts, and the two sync outputs keep the last level they drove. The registered sync and active outputs always describe the pixel that `hcount_o`, `vline_o` and `field_o` show in the same cycle.

Top module: `video_sync_gen`

## Requirements
- R1: With sleep low, `hcount_o` holds each value for exactly two clock cycles before it advances.
- R2: `hcount_o` counts from 1 to the line total (858 in 525 mode, 864 in 625 mode, parameters) and then returns to 1.
- R3: Field 1 (`field_o`=0) is (frame lines + 1)/2 lines long and field 2 (`field_o`=1) is frame lines/2 long. `vline_o` runs 1 to the field length, and `field_o` toggles when it wraps.
- R4: `vline_o` changes only in the cycle in which `hcount_o` returns to 1.
- R5: `hsync_no` is 0 exactly when `hcount_o` is in 1..H_SYNC (63) and is 1 otherwise.
- R6: When the pin is in sync mode, take the half-line index (`vline_o`-1)*2 + (`hcount_o` > line total/2). `vsync_no` is 0 while that index lies in [F, F+H), where F is the field bit and H is 6 half-lines in 525 mode and 5 in 625 mode. Field 1 sync therefore starts at pixel 1 of line 1, and field 2 sync starts at pixel total/2+1. A 625 field-1 pulse ends at pixel 432 of line 3.
- R7: When the pin is in parity mode, `vsync_no` is 1 throughout field 1 (odd) and 0 throughout field 2 (even).
- R8: `active_o` is 1 exactly when `hcount_o` lies within line total-H_FRONT-H_ACTIVE+1 .. line total-H_FRONT, and `vline_o` lies within (frame lines/2)-active lines+1 .. frame lines/2. There are 240 active lines in 525 mode and 288 in 625 mode.
- R9: While `rst_ni` is low, `hsync_no` and `vsync_no` are 1, `active_o` is 0 and the counters show pixel 1, line 1, field 1. While sleep is high, the counters are held at that same point, `active_o` is 0 and both sync outputs hold their last level. The first cycle after sleep falls shows pixel 1, line 1, field 1.
- R10: `mode625_i` (1 = 625 lines) and `field_out_i` (1 = parity) take effect only while sleep is high. Changing them while timing runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Synchronous restart and hold; mode capture while high |
| mode625_i | input | 1 | 1 selects 625-line timing, 0 selects 525-line |
| field_out_i | input | 1 | 1 puts field parity on the vertical pin |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync (active low) or field parity |
| hcount_o | output | HW | Pixel number in line, from 1 |
| vline_o | output | VW | Line number in field, from 1 |
| field_o | output | 1 | 0 for field 1, 1 for field 2 |
| active_o | output | 1 | Active picture region |

## Verification
The bench shrinks the raster to a 40-pixel line with 15 frame lines for the 525-style mode, and a 44-pixel line with 19 frame lines for the 625-style mode. Sync is 5 pixels, front porch is 3, the active width is 24, and there are 4 and 6 active lines. The 6- and 5-half-line vertical sync counts are kept at their real values. With these sizes a whole interlaced frame takes under 1,700 clocks. Each mode switch, field wrap, odd-length field, mid-line sync edge and parity case can then be reached many times over in one run.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef struct packed {
    logic lines625;
    logic field_pin;
  } vsg_cfg_t;
endpackage

// File: rtl/vsg_hcount.sv
module vsg_hcount #(
  parameter int HW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [HW-1:0] htotal_i,
  output logic [HW-1:0] hcount_o,
  output logic [HW-1:0] hnext_o,
  output logic          eol_o
);
  logic phase_q;

  always_comb begin
    eol_o = phase_q && !clr_i && (hcount_o >= htotal_i);
    if (clr_i)                   hnext_o = HW'(1);
    else if (!phase_q)           hnext_o = hcount_o;
    else if (hcount_o >= htotal_i) hnext_o = HW'(1);
    else                         hnext_o = hcount_o + HW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b0;
      hcount_o <= HW'(1);
    end else begin
      phase_q  <= clr_i ? 1'b0 : !phase_q;
      hcount_o <= hnext_o;
    end
  end
endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount #(
  parameter int VW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          eol_i,
  input  logic [VW-1:0] len_long_i,
  input  logic [VW-1:0] len_short_i,
  output logic [VW-1:0] vline_o,
  output logic          field_o,
  output logic [VW-1:0] vnext_o,
  output logic          fnext_o
);
  logic [VW-1:0] flen;

  always_comb begin
    flen    = field_o ? len_short_i : len_long_i;
    vnext_o = vline_o;
    fnext_o = field_o;
    if (clr_i) begin
      vnext_o = VW'(1);
      fnext_o = 1'b0;
    end else if (eol_i) begin
      if (vline_o >= flen) begin
        vnext_o = VW'(1);
        fnext_o = !field_o;
      end else begin
        vnext_o = vline_o + VW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vline_o <= VW'(1);
      field_o <= 1'b0;
    end else begin
      vline_o <= vnext_o;
      field_o <= fnext_o;
    end
  end
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode #(
  parameter int HW     = 10,
  parameter int VW     = 9,
  parameter int H_SYNC = 63
) (
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic          f_i,
  input  logic [HW-1:0] half_i,
  input  logic [HW-1:0] ah_first_i,
  input  logic [HW-1:0] ah_last_i,
  input  logic [VW-1:0] av_first_i,
  input  logic [VW-1:0] av_last_i,
  input  logic [VW:0]   vs_halves_i,
  input  logic          field_pin_i,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          active_o
);
  logic [VW:0] hidx, vs_start, vs_stop;
  logic        vs_on;

  always_comb begin
    // position in half-lines since field start
    hidx      = {v_i - VW'(1), (h_i > half_i)};
    vs_start  = {{VW{1'b0}}, f_i};
    vs_stop   = vs_start + vs_halves_i;
    vs_on     = (hidx >= vs_start) && (hidx < vs_stop);
    hsync_n_o = !((h_i != '0) && (h_i <= HW'(H_SYNC)));
    vsync_n_o = field_pin_i ? !f_i : !vs_on;
    active_o  = (h_i >= ah_first_i) && (h_i <= ah_last_i) &&
                (v_i >= av_first_i) && (v_i <= av_last_i);
  end
endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen #(
  parameter int H_TOTAL_A   = 858,
  parameter int H_TOTAL_B   = 864,
  parameter int H_SYNC      = 63,
  parameter int H_FRONT     = 20,
  parameter int H_ACTIVE    = 720,
  parameter int FRAME_A     = 525,
  parameter int FRAME_B     = 625,
  parameter int V_ACTIVE_A  = 240,
  parameter int V_ACTIVE_B  = 288,
  parameter int VS_HALVES_A = 6,
  parameter int VS_HALVES_B = 5,
  parameter int HW = $clog2(((H_TOTAL_A > H_TOTAL_B) ? H_TOTAL_A : H_TOTAL_B) + 1),
  parameter int VW = $clog2(((FRAME_A > FRAME_B) ? FRAME_A : FRAME_B) / 2 + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_i,
  input  logic          mode625_i,
  input  logic          field_out_i,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic [HW-1:0] hcount_o,
  output logic [VW-1:0] vline_o,
  output logic          field_o,
  output logic          active_o
);
  import vsg_pkg::*;

  localparam logic [HW-1:0] HT_A    = HW'(H_TOTAL_A);
  localparam logic [HW-1:0] HT_B    = HW'(H_TOTAL_B);
  localparam logic [HW-1:0] AHF_A   = HW'(H_TOTAL_A - H_FRONT - H_ACTIVE + 1);
  localparam logic [HW-1:0] AHF_B   = HW'(H_TOTAL_B - H_FRONT - H_ACTIVE + 1);
  localparam logic [HW-1:0] AHL_A   = HW'(H_TOTAL_A - H_FRONT);
  localparam logic [HW-1:0] AHL_B   = HW'(H_TOTAL_B - H_FRONT);
  localparam logic [VW-1:0] LONG_A  = VW'((FRAME_A + 1) / 2);
  localparam logic [VW-1:0] LONG_B  = VW'((FRAME_B + 1) / 2);
  localparam logic [VW-1:0] SHORT_A = VW'(FRAME_A / 2);
  localparam logic [VW-1:0] SHORT_B = VW'(FRAME_B / 2);
  localparam logic [VW-1:0] AVF_A   = VW'(FRAME_A / 2 - V_ACTIVE_A + 1);
  localparam logic [VW-1:0] AVF_B   = VW'(FRAME_B / 2 - V_ACTIVE_B + 1);
  localparam logic [VW:0]   VSH_A   = (VW+1)'(VS_HALVES_A);
  localparam logic [VW:0]   VSH_B   = (VW+1)'(VS_HALVES_B);

  vsg_cfg_t      cfg_q;
  logic [HW-1:0] htot, half, ah_first, ah_last, hnext;
  logic [VW-1:0] flong, fshort, av_first, vnext;
  logic [VW:0]   vs_halves;
  logic          eol, fnext;
  logic          hs_n_d, vs_n_d, act_d;

  // mode capture while held asleep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (sleep_i) cfg_q <= '{lines625: mode625_i, field_pin: field_out_i};
  end

  always_comb begin
    htot      = cfg_q.lines625 ? HT_B    : HT_A;
    ah_first  = cfg_q.lines625 ? AHF_B   : AHF_A;
    ah_last   = cfg_q.lines625 ? AHL_B   : AHL_A;
    flong     = cfg_q.lines625 ? LONG_B  : LONG_A;
    fshort    = cfg_q.lines625 ? SHORT_B : SHORT_A;
    av_first  = cfg_q.lines625 ? AVF_B   : AVF_A;
    vs_halves = cfg_q.lines625 ? VSH_B   : VSH_A;
    half      = htot >> 1;
  end

  vsg_hcount #(.HW(HW)) i_hcount (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sleep_i),
    .htotal_i (htot),
    .hcount_o (hcount_o),
    .hnext_o  (hnext),
    .eol_o    (eol)
  );

  vsg_vcount #(.VW(VW)) i_vcount (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (sleep_i),
    .eol_i       (eol),
    .len_long_i  (flong),
    .len_short_i (fshort),
    .vline_o     (vline_o),
    .field_o     (field_o),
    .vnext_o     (vnext),
    .fnext_o     (fnext)
  );

  // decode next position so registered outputs align with the counters
  vsg_decode #(.HW(HW), .VW(VW), .H_SYNC(H_SYNC)) i_decode (
    .h_i         (hnext),
    .v_i         (vnext),
    .f_i         (fnext),
    .half_i      (half),
    .ah_first_i  (ah_first),
    .ah_last_i   (ah_last),
    .av_first_i  (av_first),
    .av_last_i   (fshort),
    .vs_halves_i (vs_halves),
    .field_pin_i (cfg_q.field_pin),
    .hsync_n_o   (hs_n_d),
    .vsync_n_o   (vs_n_d),
    .active_o    (act_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_no <= 1'b1;
      vsync_no <= 1'b1;
      active_o <= 1'b0;
    end else if (sleep_i) begin
      active_o <= 1'b0;
    end else begin
      hsync_no <= hs_n_d;
      vsync_no <= vs_n_d;
      active_o <= act_d;
    end
  end
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
  parameter int HW     = 10,
  parameter int VW     = 9,
  parameter int H_SYNC = 63
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sleep_i,
  input logic          hsync_no,
  input logic          vsync_no,
  input logic [HW-1:0] hcount_o,
  input logic [VW-1:0] vline_o,
  input logic          field_o,
  input logic          active_o
);
  logic primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || sleep_i)
    $changed(hcount_o) |=> $stable(hcount_o));

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || sleep_i)
    $changed(hcount_o) |-> ((hcount_o == $past(hcount_o) + HW'(1)) || (hcount_o == HW'(1))));

  assert_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || sleep_i)
    ($changed(vline_o) || $changed(field_o)) |-> (hcount_o == HW'(1)));

  assert_hsync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && !$past(sleep_i)) |->
      (hsync_no == !((hcount_o != '0) && (hcount_o <= HW'(H_SYNC)))));

  assert_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && !hsync_no));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(sleep_i)) |-> ($stable(hsync_no) && $stable(vsync_no) && !active_o));
endmodule

bind video_sync_gen vsg_checker #(.HW(HW), .VW(VW), .H_SYNC(H_SYNC)) i_vsg_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sleep_i  (sleep_i),
  .hsync_no (hsync_no),
  .vsync_no (vsync_no),
  .hcount_o (hcount_o),
  .vline_o  (vline_o),
  .field_o  (field_o),
  .active_o (active_o)
);

// File: tb/test_video_sync_gen.sv
module test_video_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HT_A = 40, HT_B = 44, HS = 5, HF = 3, HA = 24;
  localparam int FR_A = 15, FR_B = 19, VA_A = 4, VA_B = 6;
  localparam int HW = $clog2(((HT_A > HT_B) ? HT_A : HT_B) + 1);
  localparam int VW = $clog2(((FR_A > FR_B) ? FR_A : FR_B) / 2 + 2);
  localparam int WATCHDOG = 150000;
  localparam int NV = 27;
  // {mode625, parity, line[7:0], pixel[7:0], field, hsync_n, vsync_n, active}
  localparam logic [21:0] TBL [NV] = '{
    {1'b0,1'b0,8'd1, 8'd1, 1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'd1, 8'd6, 1'b0,1'b1,1'b0,1'b0},
    {1'b0,1'b0,8'd2, 8'd5, 1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b0,8'd3, 8'd40,1'b0,1'b1,1'b0,1'b0},
    {1'b0,1'b0,8'd4, 8'd1, 1'b0,1'b0,1'b1,1'b0},
    {1'b0,1'b0,8'd4, 8'd14,1'b0,1'b1,1'b1,1'b1},
    {1'b0,1'b0,8'd7, 8'd37,1'b0,1'b1,1'b1,1'b1},
    {1'b0,1'b0,8'd7, 8'd38,1'b0,1'b1,1'b1,1'b0},
    {1'b0,1'b0,8'd8, 8'd20,1'b0,1'b1,1'b1,1'b0},
    {1'b0,1'b0,8'd1, 8'd20,1'b1,1'b1,1'b1,1'b0},
    {1'b0,1'b0,8'd1, 8'd21,1'b1,1'b1,1'b0,1'b0},
    {1'b0,1'b0,8'd4, 8'd20,1'b1,1'b1,1'b0,1'b1},
    {1'b0,1'b0,8'd4, 8'd21,1'b1,1'b1,1'b1,1'b1},
    {1'b0,1'b0,8'd4, 8'd13,1'b1,1'b1,1'b0,1'b0},
    {1'b0,1'b0,8'd4, 8'd14,1'b1,1'b1,1'b0,1'b1},
    {1'b1,1'b0,8'd3, 8'd22,1'b0,1'b1,1'b0,1'b0},
    {1'b1,1'b0,8'd3, 8'd23,1'b0,1'b1,1'b1,1'b0},
    {1'b1,1'b0,8'd1, 8'd22,1'b1,1'b1,1'b1,1'b0},
    {1'b1,1'b0,8'd1, 8'd23,1'b1,1'b1,1'b0,1'b0},
    {1'b1,1'b0,8'd3, 8'd44,1'b1,1'b1,1'b0,1'b0},
    {1'b1,1'b0,8'd4, 8'd1, 1'b1,1'b0,1'b1,1'b0},
    {1'b1,1'b0,8'd9, 8'd41,1'b1,1'b1,1'b1,1'b1},
    {1'b1,1'b0,8'd10,8'd18,1'b0,1'b1,1'b1,1'b0},
    {1'b1,1'b0,8'd3, 8'd17,1'b0,1'b1,1'b0,1'b0},
    {1'b0,1'b1,8'd1, 8'd1, 1'b0,1'b0,1'b1,1'b0},
    {1'b0,1'b1,8'd2, 8'd5, 1'b1,1'b0,1'b0,1'b0},
    {1'b1,1'b1,8'd5, 8'd30,1'b1,1'b1,1'b0,1'b1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep_i = 1'b0;
  logic          mode625_i = 1'b0;
  logic          field_out_i = 1'b0;
  logic          hsync_no, vsync_no, field_o, active_o;
  logic [HW-1:0] hcount_o;
  logic [VW-1:0] vline_o;
  int checks = 0, failures = 0, cycles = 0;

  video_sync_gen #(
    .H_TOTAL_A(HT_A), .H_TOTAL_B(HT_B), .H_SYNC(HS), .H_FRONT(HF), .H_ACTIVE(HA),
    .FRAME_A(FR_A), .FRAME_B(FR_B), .V_ACTIVE_A(VA_A), .V_ACTIVE_B(VA_B),
    .VS_HALVES_A(6), .VS_HALVES_B(5)
  ) i_video_sync_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .mode625_i(mode625_i),
    .field_out_i(field_out_i), .hsync_no(hsync_no), .vsync_no(vsync_no),
    .hcount_o(hcount_o), .vline_o(vline_o), .field_o(field_o), .active_o(active_o)
  );

  always #(CLK_PERIOD/2) clk_i = !clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog all-R actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic m, input logic fo);
    @(negedge clk_i);
    sleep_i = 1'b1; mode625_i = m; field_out_i = fo;
    repeat (3) @(negedge clk_i);
    sleep_i = 1'b0;
  endtask

  task automatic seek(input int ln, input int px, input logic f);
    bit hit = 0;
    for (int i = 0; i < 20000 && !hit; i++) begin
      @(negedge clk_i);
      if (int'(vline_o) == ln && int'(hcount_o) == px && field_o == f) hit = 1;
    end
    check("R3 seek reach", int'(hit), 1);
  endtask

  initial begin
    int n, hmax, m0, m1;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 rst hsync", hsync_no, 1);
    check("R9 rst vsync", vsync_no, 1);
    check("R9 rst active", active_o, 0);
    check("R9 rst hcount", hcount_o, 1);
    check("R9 rst vline", vline_o, 1);
    check("R9 rst field", field_o, 0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      configure(TBL[k][21], TBL[k][20]);
      seek(int'(TBL[k][19:12]), int'(TBL[k][11:4]), TBL[k][3]);
      check($sformatf("R5 table %0d hsync", k), hsync_no, TBL[k][2]);
      check($sformatf("%s table %0d vsync", TBL[k][20] ? "R7" : "R6", k), vsync_no, TBL[k][1]);
      check($sformatf("R8 table %0d active", k), active_o, TBL[k][0]);
    end

    // R1 two clocks per pixel
    configure(1'b0, 1'b0);
    seek(1, 2, 1'b0);
    n = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (hcount_o != HW'(2)) break;
      n++;
    end
    check("R1 clocks per pixel", n, 2);

    // R2 line wrap and R4 line advance point, both modes
    for (int md = 0; md < 2; md++) begin
      configure(md[0], 1'b0);
      seek(1, 1, 1'b0);
      hmax = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk_i);
        if (int'(hcount_o) > hmax) hmax = int'(hcount_o);
        if (vline_o == VW'(2)) break;
      end
      check("R2 line total", hmax, md ? HT_B : HT_A);
      check("R4 hcount at line step", hcount_o, 1);
    end

    // R3 field lengths, both modes
    for (int md = 0; md < 2; md++) begin
      configure(md[0], 1'b0);
      m0 = 0; m1 = 0;
      for (int i = 0; i < 2 * 2 * (md ? FR_B * HT_B : FR_A * HT_A) + 8; i++) begin
        @(negedge clk_i);
        if (!field_o && int'(vline_o) > m0) m0 = int'(vline_o);
        if (field_o && int'(vline_o) > m1) m1 = int'(vline_o);
      end
      check("R3 field1 lines", m0, md ? (FR_B + 1) / 2 : (FR_A + 1) / 2);
      check("R3 field2 lines", m1, md ? FR_B / 2 : FR_A / 2);
    end

    // R9 sleep hold with hsync low, then high
    configure(1'b0, 1'b0);
    seek(1, 3, 1'b0);
    sleep_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R9 sleep hold hsync low", hsync_no, 0);
    check("R9 sleep hold vsync low", vsync_no, 0);
    check("R9 sleep hcount", hcount_o, 1);
    check("R9 sleep vline", vline_o, 1);
    sleep_i = 1'b0;
    seek(2, 10, 1'b0);
    sleep_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R9 sleep hold hsync high", hsync_no, 1);
    check("R9 sleep hold vsync", vsync_no, 0);
    check("R9 sleep active", active_o, 0);
    sleep_i = 1'b0;
    @(negedge clk_i);
    check("R9 restart hcount", hcount_o, 1);
    check("R9 restart vline", vline_o, 1);
    check("R9 restart field", field_o, 0);
    check("R9 restart hsync", hsync_no, 0);
    check("R9 restart vsync", vsync_no, 0);

    // R10 pins ignored while running
    configure(1'b0, 1'b0);
    mode625_i = 1'b1; field_out_i = 1'b1;
    seek(1, 1, 1'b0);
    hmax = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (int'(hcount_o) > hmax) hmax = int'(hcount_o);
      if (vline_o == VW'(2)) break;
    end
    check("R10 line total unchanged", hmax, HT_A);
    seek(4, 21, 1'b1);
    check("R10 vsync mode unchanged", vsync_no, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule